// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

The controller gathers interrupt causes from on-chip sources and from a second status register that tracks DMA channel events. It shows them to a host through four word registers: a coalescing control word, the main status word, an enable mask and the DMA status word. Status bits are sticky. The host clears a bit by writing a 1 to its position. One level-sensitive interrupt line, `irq`, goes high when any status bit that is enabled in the mask is pending.

To cut the host's interrupt load, the line can be held back for a programmable number of 32 µs ticks while more causes gather. A high-priority receive event skips this delay. A second timer, held in the upper byte of the coalescing word, sets a periodic-receive cause at a fixed interval. A free-running prescaler turns the block clock into the 32 µs tick. Its divide ratio is the parameter `TICK_DIV`.

The register port is a plain single-cycle interface: a write strobe, a word address, write data, and read data that follows the address combinationally. Word address 0 is the coalescing word, 1 the main status, 2 the mask and 3 the DMA status.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Direct cause pulses on `cause_set` bits 26, 25, 7, 6, 1 and 0 set the same bits of main status (word address 1).
  - Writing a 1 there clears the bit on the next clock edge; writing 0 leaves it unchanged.
  - A cause pulse in the same cycle as a clear wins.
- R3: Only the implemented bits exist. Main status bits other than 31, 29, 28, 27, 26, 25, 7, 6, 1 and 0 read 0. DMA status bits other than 31, 30, 17, 16, 1 and 0 read 0.
- R4: `irq` is high only while the main status ANDed with the mask (word address 2) is nonzero.
  - Clearing the last enabled pending bit drops `irq` right after that write's clock edge.
- R5: The coalescing window is the low byte of word address 0 and is counted in prescaler ticks.
  - With a window of 0, `irq` rises one clock edge after the edge that captured the cause.
  - With a window of W>0, `irq` rises no earlier than (W-1)·TICK_DIV+1 and no later than W·TICK_DIV+2 edges after that capture.
- R6: A DMA status bit 30 event (high-priority receive), with mask bit 31 set, raises `irq` two edges after the pulse is captured, whatever the window.
- R7: DMA status (word address 3) is set by `dma_set` pulses and cleared by writing ones. It folds into three main summary bits:
  - main bit 31 from DMA bits 16, 17 and 30;
  - main bit 27 from DMA bits 0 and 1;
  - main bit 29 from DMA bit 31.
  - A summary bit is set again every cycle while any of its DMA bits is still set, and stays set after they clear until the host clears it.
- R8: The upper byte of word address 0 is the periodic period P in ticks.
  - P=0 never sets main bit 28.
  - P>0 sets bit 28 every P ticks, counted afresh from each write of word address 0.
- R9: Once `irq` is high it stays high, and new causes do not restart anything, until every enabled pending bit is cleared. Only after that does the next cause start a fresh full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Word address: 0 coalescing, 1 status, 2 mask, 3 DMA status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cause_set | input | 32 | One-cycle cause pulses from internal sources, per main status bit |
| dma_set | input | 32 | One-cycle DMA event pulses, per DMA status bit |
| irq | output | 1 | Host interrupt line, active high |

## Verification
The fold from DMA status into summary bits is driven with random mixes of cause and DMA pulses and random write-one clear patterns. Each status word is then compared with a model that keeps summary bits alive while their DMA sources remain. Directed runs measure how many edges pass between a captured cause and `irq` in four cases: a zero window, a three-tick window, a high-priority receive event and a periodic expiry. Those counts separate an immediate path, a tick-counted path and the bypass. Further cases hold `irq` across added causes and partial clears, then check that a fresh window follows a full clear, which shows whether the counter restarts at the right moment.

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
  parameter int TICK_DIV = 8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] cause_set,
  input  logic [31:0] dma_set,
  output logic        irq
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [31:0] DIRECT_BITS = 32'h0600_00C3;
  localparam logic [31:0] DMA_BITS    = 32'hC003_0003;

  logic [TICK_W-1:0] pre_q;
  logic [15:0]       coal_q;
  logic [31:0]       stat_q, mask_q, dma_q;
  logic [7:0]        per_cnt, win_cnt;
  logic              asserted;

  logic        tick, per_fire, pending, hp;
  logic        wr_coal, wr_stat, wr_mask, wr_dma;
  logic [7:0]  win, per;
  logic [31:0] sum_set;

  assign wr_coal = reg_wr && reg_addr == 2'd0;
  assign wr_stat = reg_wr && reg_addr == 2'd1;
  assign wr_mask = reg_wr && reg_addr == 2'd2;
  assign wr_dma  = reg_wr && reg_addr == 2'd3;

  assign win  = coal_q[7:0];
  assign per  = coal_q[15:8];
  assign tick = (pre_q == TICK_W'(TICK_DIV - 1));

  assign sum_set = {dma_q[30] | dma_q[17] | dma_q[16], 1'b0, dma_q[31], 1'b0,
                    dma_q[1] | dma_q[0], 27'd0};

  assign per_fire = tick && !wr_coal && per != 8'd0 && per_cnt == per - 8'd1;
  assign pending  = |(stat_q & mask_q);
  assign hp       = dma_q[30] & mask_q[31];
  assign irq      = asserted & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coal_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_coal) coal_q <= reg_wdata[15:0];
      if (wr_mask) mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q  <= '0;
      stat_q <= '0;
    end else begin
      dma_q  <= (dma_q & ~(wr_dma ? reg_wdata : 32'd0)) | (dma_set & DMA_BITS);
      stat_q <= (stat_q & ~(wr_stat ? reg_wdata : 32'd0))
              | (cause_set & DIRECT_BITS)
              | sum_set
              | {3'd0, per_fire, 28'd0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_cnt <= '0;
    else if (wr_coal || per == 8'd0) per_cnt <= '0;
    else if (tick) per_cnt <= per_fire ? 8'd0 : per_cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asserted <= 1'b0;
      win_cnt  <= '0;
    end else if (!pending) begin
      asserted <= 1'b0;
      win_cnt  <= '0;
    end else if (!asserted) begin
      if (win == 8'd0 || hp || win_cnt >= win) asserted <= 1'b1;
      else if (tick) win_cnt <= win_cnt + 8'd1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {16'd0, coal_q};
      2'd1:    reg_rdata = stat_q;
      2'd2:    reg_rdata = mask_q;
      default: reg_rdata = dma_q;
    endcase
  end

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic host_wr,
  input logic wr_stat,
  input logic wd0,
  input logic wd25,
  input logic set0,
  input logic st0,
  input logic st25,
  input logic st27,
  input logic st28,
  input logic tx_src,
  input logic mask_none,
  input logic per_off
);

  a_r2_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wd0 && !set0) |=> !st0);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st25 && !(wr_stat && wd25)) |=> st25);

  a_r7_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    tx_src |=> st27);

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask_none |-> !irq);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !host_wr) |=> irq);

  a_r8_periodic_off: assert property (@(posedge clk) disable iff (!rst_n)
    per_off |=> !$rose(st28));

endmodule

bind irq_coalesce_ctrl irq_coalesce_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .host_wr   (reg_wr),
  .wr_stat   (reg_wr && reg_addr == 2'd1),
  .wd0       (reg_wdata[0]),
  .wd25      (reg_wdata[25]),
  .set0      (cause_set[0]),
  .st0       (stat_q[0]),
  .st25      (stat_q[25]),
  .st27      (stat_q[27]),
  .st28      (stat_q[28]),
  .tx_src    (dma_q[1] | dma_q[0]),
  .mask_none (mask_q == 32'd0),
  .per_off   (coal_q[15:8] == 8'd0)
);

// File: tb/test_irq_coalesce_ctrl.sv
module test_irq_coalesce_ctrl;

  localparam int D = 4;
  localparam logic [31:0] DIRECT = 32'h0600_00C3;
  localparam logic [31:0] DMAIMP = 32'hC003_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] cause_set = 32'd0;
  logic [31:0] dma_set = 32'd0;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_coalesce_ctrl #(.TICK_DIV(D)) i_irq_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cause_set(cause_set),
    .dma_set(dma_set), .irq(irq)
  );

  function automatic logic [31:0] fold(input logic [31:0] d);
    fold = 32'd0;
    fold[31] = d[30] | d[17] | d[16];
    fold[29] = d[31];
    fold[27] = d[1] | d[0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int n, input int lo, input int hi);
    total++;
    if (n < lo || n > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] c, input logic [31:0] dm);
    @(negedge clk);
    cause_set = c; dma_set = dm;
    @(negedge clk);
    cause_set = 32'd0; dma_set = 32'd0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, am, ad, cm, cd;
    int n;
    void'($urandom(32'd20250));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reset reg", d, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R3 all-ones pulses, mask off
    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle(2);
    rd(2'd1, d); check("R3 main implemented", d, DIRECT | fold(DMAIMP));
    rd(2'd3, d); check("R3 dma implemented", d, DMAIMP);
    wr(2'd1, 32'd0);
    rd(2'd1, d); check("R2 write zero no effect", d, DIRECT | fold(DMAIMP));
    clear_all();
    rd(2'd1, d); check("R2 clear all main", d, 32'd0);
    rd(2'd3, d); check("R7 clear all dma", d, 32'd0);

    // R2 set wins over clear in the same cycle
    @(negedge clk);
    cause_set = 32'h0000_0040; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0040;
    @(negedge clk);
    cause_set = 32'd0; reg_wr = 1'b0; reg_wdata = 32'd0;
    rd(2'd1, d); check("R2 set beats clear", d, 32'h0000_0040);
    wr(2'd1, 32'h0000_0040);

    // R7 summary held while source set
    pulse(32'd0, 32'h0001_0000);
    idle(1);
    wr(2'd1, 32'h8000_0000);
    idle(1);
    rd(2'd1, d); check("R7 summary reasserts", d, 32'h8000_0000);
    wr(2'd3, 32'h0001_0000);
    rd(2'd1, d); check("R7 summary sticky after source clear", d, 32'h8000_0000);
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, d); check("R7 summary cleared", d, 32'd0);

    // R2 R7 random mix
    am = 32'd0; ad = 32'd0;
    for (int i = 0; i < 24; i++) begin
      cm = $urandom & DIRECT;
      cd = $urandom & DMAIMP;
      pulse(cm, cd);
      ad |= cd;
      am |= cm | fold(cd);
      idle(1);
      rd(2'd1, d); check("R7 random main", d, am);
      rd(2'd3, d); check("R7 random dma", d, ad);
      cd = $urandom;
      wr(2'd3, cd);
      ad &= ~cd;
      cm = $urandom;
      wr(2'd1, cm);
      am = (am & ~cm) | fold(ad);
      rd(2'd1, d); check("R2 random clear", d, am);
    end
    clear_all();

    // R4 mask gating
    wr(2'd2, 32'h0000_0040);
    pulse(32'h0000_0001, 32'd0);
    idle(5);
    check("R4 masked cause quiet", {31'd0, irq}, 32'd0);
    pulse(32'h0000_0040, 32'd0);
    wait_irq(n);
    check_range("R5 zero window latency", n, 1, 1);
    wr(2'd1, 32'h0000_0040);
    check("R4 irq drops on clear", {31'd0, irq}, 32'd0);
    rd(2'd1, d); check("R4 masked bit kept", d, 32'h0000_0001);
    clear_all();

    // R5 three-tick window
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0000_0003);
    pulse(32'h0000_0001, 32'd0);
    wait_irq(n);
    check_range("R5 window delay", n, 2 * D + 1, 3 * D + 2);
    clear_all();
    idle(2);

    // R6 high-priority bypass
    pulse(32'd0, 32'h4000_0000);
    wait_irq(n);
    check_range("R6 bypass latency", n, 2, 2);
    clear_all();
    check("R6 irq low after clear", {31'd0, irq}, 32'd0);

    // R9 hold and restart
    pulse(32'h0000_0001, 32'd0);
    wait_irq(n);
    pulse(32'h0000_0002, 32'd0);
    idle(5);
    check("R9 holds with new cause", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h0000_0001);
    check("R9 holds on partial clear", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h0000_0002);
    check("R9 low after full clear", {31'd0, irq}, 32'd0);
    pulse(32'h0200_0000, 32'd0);
    wait_irq(n);
    check_range("R9 fresh window", n, 2 * D + 1, 3 * D + 2);
    clear_all();

    // R8 periodic timer
    wr(2'd2, 32'h1000_0000);
    wr(2'd0, 32'h0000_0200);
    wait_irq(n);
    check_range("R8 periodic expiry", n, D + 1, 2 * D + 2);
    rd(2'd1, d); check("R8 periodic bit", d, 32'h1000_0000);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(10 * D);
    rd(2'd1, d); check("R8 disabled stays clear", d, 32'd0);
    check("R8 irq low disabled", {31'd0, irq}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule